// File: doc/BRIEF.md
# Serial Audio-Link Frame Deserializer

This block receives a serial audio/modem link at the bit level. The link carries a bit clock, a frame-sync line and two data lines: one from the controller to the codec and one from the codec back to the controller. The block oversamples these four wires with its own system clock and detects each falling edge of the bit clock. On that edge it samples the sync line and both data lines.

A frame holds exactly 256 bits. It begins on the bit whose two preceding sync samples were low and then high. The frame is cut into thirteen slots: the first is 16 bits wide and the twelve that follow are 20 bits wide each. Every completed slot is reported on one parallel output as the slot index, a 20-bit value, a direction flag and a one-cycle strobe. The block also gives a one-cycle frame-start pulse and a one-cycle short-frame pulse.

A frame can be restarted early, before all of its bits have arrived. The slots already completed in that frame are still reported, the partly received slot is dropped, and counting starts again at slot 0.

Top module: `ac97_frame_deser`

## Requirements
- R1: After reset every output is 0. No slot strobe and no frame-start pulse is produced until the first frame start has been detected; data bits seen before it are ignored.
- R2: A frame starts on the falling bit-clock edge at which the two previous sync samples were 0 (older) then 1 (newer). `frame_start` pulses once for that bit. If sync stays high for several bits, no further start is triggered.
- R3: Slot 0 covers frame bits 0..15 and slot k (1..12) covers bits 16+20(k-1) .. 35+20(k-1). Each enabled direction gives exactly 13 strobes per complete frame, with `slot_index` running 0..12 in order.
- R4: Data and sync are sampled on the falling edge of `bit_clk`. A slot value is built MSB first, so the first bit of the slot becomes the most significant bit of the slot's width.
- R5: The 16-bit slot 0 value is right-aligned in `slot_data`, and bits 19..16 are 0.
- R6: The two data lines are captured independently. `slot_dir` is 0 for `sdata_out` and 1 for `sdata_in`. When both are enabled, the `sdata_in` strobe for a slot comes in the cycle right after the `sdata_out` strobe for the same slot.
- R7: Bits that arrive after frame bit 255 and before the next detected frame start produce no strobe.
- R8: If a frame start is detected before 256 bits have arrived, `short_frame` pulses in the same cycle as `frame_start`. Slots already completed are kept, the partial slot is not reported, and slot counting restarts at slot 0.
- R9: Parameters `OUT_EN` and `IN_EN` disable capture of one line. A disabled direction never produces a strobe, and the other direction is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the link |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Link bit clock |
| sync | input | 1 | Link frame-sync line |
| sdata_out | input | 1 | Controller-to-codec data line |
| sdata_in | input | 1 | Codec-to-controller data line |
| frame_start | output | 1 | One-cycle pulse when a frame start is detected |
| short_frame | output | 1 | One-cycle pulse when a frame is restarted before 256 bits |
| slot_strobe | output | 1 | One-cycle strobe for a completed slot |
| slot_dir | output | 1 | 0 = slot taken from sdata_out, 1 = from sdata_in |
| slot_index | output | 4 | Slot number 0..12 |
| slot_data | output | 20 | Slot value, MSB first; slot 0 is right-aligned |

## Verification
With two synchronizer stages, the falling bit-clock edge is seen as a tick in the second system-clock cycle after it. `frame_start` and `short_frame` rise after the third rising edge. The `sdata_out` slot strobe rises after the fourth edge, and the `sdata_in` strobe one cycle later.

The bench pushes each expected slot into a queue while it drives that slot's last bit. A monitor sampling on the falling system-clock edge pops and compares each strobe as it arrives, and it also checks that the `sdata_in` strobe directly follows its `sdata_out` partner. Count checks wait at least twenty system cycles after the last bit, well past the five-cycle latency, and a second instance with one line disabled is counted alongside.

// File: rtl/ac97_deser_pkg.sv
package ac97_deser_pkg;

    localparam int NUM_SLOTS  = 13;
    localparam int SLOT_W     = 20;
    localparam int TAG_W      = 16;
    localparam int FRAME_BITS = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
    localparam int POS_W      = $clog2(SLOT_W);

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [SLOT_W-1:0]     slot_val_t;
    typedef logic [POS_W-1:0]      slot_pos_t;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } dir_e;

    // raw link wires, one synchronizer stage
    typedef struct packed {
        logic bclk;
        logic sync;
        logic sd_out;
        logic sd_in;
    } line_t;

    // one sampled bit time
    typedef struct packed {
        logic tick;
        logic sync;
        logic sd_out;
        logic sd_in;
    } bit_ev_t;

    // what the tracker decides for the current bit
    typedef struct packed {
        logic      accept;
        logic      start;
        logic      last;
        slot_idx_t slot;
    } step_t;

    typedef struct packed {
        logic      valid;
        dir_e      dir;
        slot_idx_t slot;
        slot_val_t value;
    } slot_word_t;

    function automatic slot_pos_t slot_last_pos(slot_idx_t s);
        return (s == '0) ? slot_pos_t'(TAG_W - 1) : slot_pos_t'(SLOT_W - 1);
    endfunction

endpackage

// File: rtl/ac97_link_sampler.sv
module ac97_link_sampler
    import ac97_deser_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_clk,
    input  logic    sync,
    input  logic    sd_out,
    input  logic    sd_in,
    output bit_ev_t ev
);

    line_t stg [STAGES];
    logic  bclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            bclk_prev <= 1'b0;
        end else begin
            stg[0] <= '{bclk: bit_clk, sync: sync, sd_out: sd_out, sd_in: sd_in};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            bclk_prev <= stg[STAGES-1].bclk;
        end
    end

    always_comb begin
        ev.tick   = bclk_prev & ~stg[STAGES-1].bclk;
        ev.sync   = stg[STAGES-1].sync;
        ev.sd_out = stg[STAGES-1].sd_out;
        ev.sd_in  = stg[STAGES-1].sd_in;
    end

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        ev.tick |=> !ev.tick);

endmodule

// File: rtl/ac97_frame_tracker.sv
module ac97_frame_tracker
    import ac97_deser_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bit_ev_t ev,
    output step_t   step,
    output logic    frame_start_o,
    output logic    short_o
);

    logic      sync_h1, sync_h2;
    logic      active_q;
    slot_idx_t slot_q;
    slot_pos_t pos_q;

    logic      start, done;
    slot_idx_t cur_slot;
    slot_pos_t cur_pos;

    always_comb begin
        start       = ev.tick & sync_h1 & ~sync_h2;
        done        = (slot_q == slot_idx_t'(NUM_SLOTS));
        cur_slot    = start ? '0 : slot_q;
        cur_pos     = start ? '0 : pos_q;
        step.start  = start;
        step.slot   = cur_slot;
        step.accept = ev.tick & (start | (active_q & ~done));
        step.last   = step.accept & (cur_pos == slot_last_pos(cur_slot));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_h1       <= 1'b0;
            sync_h2       <= 1'b0;
            active_q      <= 1'b0;
            slot_q        <= '0;
            pos_q         <= '0;
            frame_start_o <= 1'b0;
            short_o       <= 1'b0;
        end else begin
            if (ev.tick) begin
                sync_h2 <= sync_h1;
                sync_h1 <= ev.sync;
            end
            if (start) active_q <= 1'b1;
            if (step.accept) begin
                if (step.last) begin
                    slot_q <= slot_idx_t'(cur_slot + 1'b1);
                    pos_q  <= '0;
                end else begin
                    slot_q <= cur_slot;
                    pos_q  <= slot_pos_t'(cur_pos + 1'b1);
                end
            end
            frame_start_o <= start;
            short_o       <= start & active_q & ~done;
        end
    end

    // R3
    pos_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && slot_q < slot_idx_t'(NUM_SLOTS)) |-> (pos_q <= slot_last_pos(slot_q)));

    // R8
    short_with_start_chk: assert property (@(posedge clk) disable iff (rst)
        short_o |-> frame_start_o);

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);

endmodule

// File: rtl/ac97_slot_shifter.sv
module ac97_slot_shifter
    import ac97_deser_pkg::*;
#(
    parameter bit   ENABLE = 1'b1,
    parameter dir_e DIR    = DIR_OUT
) (
    input  logic       clk,
    input  logic       rst,
    input  step_t      step,
    input  logic       bit_in,
    output slot_word_t word
);

    generate
        if (ENABLE) begin : g_on
            slot_val_t sreg, nxt;

            always_comb begin
                if (step.start) nxt = slot_val_t'(bit_in);
                else            nxt = {sreg[SLOT_W-2:0], bit_in};
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    sreg <= '0;
                    word <= '0;
                end else begin
                    word.valid <= 1'b0;
                    if (step.accept) begin
                        if (step.last) begin
                            sreg       <= '0;
                            word.valid <= 1'b1;
                            word.dir   <= DIR;
                            word.slot  <= step.slot;
                            word.value <= nxt;
                        end else begin
                            sreg <= nxt;
                        end
                    end
                end
            end

            // R5
            tag_aligned_chk: assert property (@(posedge clk) disable iff (rst)
                (word.valid && word.slot == '0) |-> (word.value[SLOT_W-1:TAG_W] == '0));
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{step, bit_in};
            assign word = '0;
        end
    endgenerate

endmodule

// File: rtl/ac97_frame_deser.sv
module ac97_frame_deser
    import ac97_deser_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit OUT_EN      = 1'b1,
    parameter bit IN_EN       = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_clk,
    input  logic                  sync,
    input  logic                  sdata_out,
    input  logic                  sdata_in,
    output logic                  frame_start,
    output logic                  short_frame,
    output logic                  slot_strobe,
    output logic                  slot_dir,
    output logic [SLOT_IDX_W-1:0] slot_index,
    output logic [SLOT_W-1:0]     slot_data
);

    bit_ev_t    ev;
    step_t      step;
    slot_word_t w_out, w_in, pend, outw;
    logic       seen_start;

    ac97_link_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .sync(sync),
        .sd_out(sdata_out), .sd_in(sdata_in), .ev(ev)
    );

    ac97_frame_tracker u_tracker (
        .clk(clk), .rst(rst), .ev(ev), .step(step),
        .frame_start_o(frame_start), .short_o(short_frame)
    );

    ac97_slot_shifter #(.ENABLE(OUT_EN), .DIR(DIR_OUT)) u_shift_out (
        .clk(clk), .rst(rst), .step(step), .bit_in(ev.sd_out), .word(w_out)
    );

    ac97_slot_shifter #(.ENABLE(IN_EN), .DIR(DIR_IN)) u_shift_in (
        .clk(clk), .rst(rst), .step(step), .bit_in(ev.sd_in), .word(w_in)
    );

    // Both lines finish a slot on the same tick: the out-line word goes
    // first, the in-line word waits one cycle in pend.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= '0;
            outw       <= '0;
            seen_start <= 1'b0;
        end else begin
            seen_start <= seen_start | frame_start;
            if (w_out.valid)      outw       <= w_out;
            else if (pend.valid)  outw       <= pend;
            else                  outw.valid <= 1'b0;
            if (w_in.valid)                      pend       <= w_in;
            else if (!w_out.valid && pend.valid) pend.valid <= 1'b0;
        end
    end

    assign slot_strobe = outw.valid;
    assign slot_dir    = outw.dir;
    assign slot_index  = outw.slot;
    assign slot_data   = outw.value;

    // R1
    no_strobe_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |-> seen_start);

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |-> (slot_index < SLOT_IDX_W'(NUM_SLOTS)));

    // R6
    in_follows_out_chk: assert property (@(posedge clk) disable iff (rst)
        (OUT_EN && IN_EN && slot_strobe && !slot_dir) |=>
            (slot_strobe && slot_dir && slot_index == $past(slot_index)));

    // R9
    dir_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        slot_strobe |-> (slot_dir ? IN_EN : OUT_EN));

endmodule

// File: tb/test_ac97_frame_deser.sv
module test_ac97_frame_deser;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0, sync_l = 1'b0, sdo = 1'b0, sdi = 1'b0;

    logic        fs, sf, stb, dir;
    logic [3:0]  idx;
    logic [19:0] dat;
    logic        fs2, sf2, stb2, dir2;
    logic [3:0]  idx2;
    logic [19:0] dat2;

    int checks = 0, failures = 0;
    int strobes = 0, starts = 0, shorts = 0;
    int exp_starts = 0, exp_dir0 = 0;
    int o2_dir0 = 0, o2_dir1 = 0;
    logic [24:0] expq[$];
    logic prev_stb = 1'b0, prev_dir = 1'b0;
    logic [3:0] prev_idx = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ac97_frame_deser i_ac97_frame_deser (
        .clk(clk), .rst(rst), .bit_clk(bclk), .sync(sync_l),
        .sdata_out(sdo), .sdata_in(sdi), .frame_start(fs), .short_frame(sf),
        .slot_strobe(stb), .slot_dir(dir), .slot_index(idx), .slot_data(dat)
    );

    ac97_frame_deser #(.IN_EN(1'b0)) i_ac97_frame_deser_oonly (
        .clk(clk), .rst(rst), .bit_clk(bclk), .sync(sync_l),
        .sdata_out(sdo), .sdata_in(sdi), .frame_start(fs2), .short_frame(sf2),
        .slot_strobe(stb2), .slot_dir(dir2), .slot_index(idx2), .slot_data(dat2)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] pat(int seed, int d, int s);
        logic [19:0] v;
        case (seed)
            0:       v = 20'hFFFFF;
            1:       v = d ? 20'h55555 : 20'hAAAAA;
            default: v = 20'((seed * 32'h9E3B) + (s * 32'h1F35) + (d * 32'h7A1) ^ (s << 14));
        endcase
        if (s == 0) v[19:16] = 4'h0;
        return v;
    endfunction

    task automatic drive_bit(input logic s, input logic o, input logic i);
        bclk = 1'b1; sync_l = s; sdo = o; sdi = i;
        #40;
        bclk = 1'b0;
        #40;
    endtask

    // nbits < 256 ends the frame early by raising sync on its last bit
    task automatic send_frame(input int seed, input int nbits, input bit follow);
        exp_starts++;
        for (int k = 0; k < nbits; k++) begin
            int s, p, len;
            logic [19:0] vo, vi;
            logic sy;
            s   = (k < 16) ? 0 : 1 + (k - 16) / 20;
            p   = (k < 16) ? k : (k - 16) % 20;
            len = (s == 0) ? 16 : 20;
            vo  = pat(seed, 0, s);
            vi  = pat(seed, 1, s);
            if (nbits < 256) sy = (k < 15) || (k == nbits - 1);
            else             sy = (k < 15) || (k == 255 && follow);
            if (p == len - 1) begin
                expq.push_back({1'b0, 4'(s), vo});
                expq.push_back({1'b1, 4'(s), vi});
                exp_dir0++;
            end
            drive_bit(sy, vo[len-1-p], vi[len-1-p]);
        end
    endtask

    task automatic idle_bits(input int n);
        for (int k = 0; k < n; k++) drive_bit(1'b0, 1'b1, 1'b1);
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (fs) starts++;
            if (sf) shorts++;
            if (stb2) begin
                if (dir2) o2_dir1++; else o2_dir0++;
            end
            if (stb) begin
                strobes++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected strobe", {dir, idx, dat}, 0);
                end else begin
                    logic [24:0] e;
                    e = expq.pop_front();
                    chk({dir, idx, dat} == e, (idx == 0) ? "R5" : "R4",
                        "slot word {dir,idx,data}", {dir, idx, dat}, e);
                    if (dir)
                        chk(prev_stb && !prev_dir && prev_idx == idx, "R6",
                            "in-line strobe follows out-line strobe", prev_idx, idx);
                end
            end
            prev_stb = stb; prev_dir = dir; prev_idx = idx;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        chk({fs, sf, stb, dir, idx, dat} == '0, "R1", "outputs after reset",
            {fs, sf, stb, dir, idx, dat}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: data before any frame start is ignored
        idle_bits(40);
        settle();
        chk(strobes == 0, "R1", "strobes before first frame", strobes, 0);
        chk(starts == 0, "R1", "frame starts before first sync", starts, 0);

        // preamble: sync high one bit before bit 0
        drive_bit(1'b1, 1'b0, 1'b0);
        send_frame(0, 256, 1'b1);
        send_frame(1, 256, 1'b1);
        settle();
        chk(expq.size() == 0, "R3", "all slots of two frames delivered", expq.size(), 0);
        chk(strobes == 52, "R3", "strobes in two frames", strobes, 52);
        chk(starts == 2, "R2", "one start per frame despite long sync", starts, 2);
        chk(shorts == 0, "R8", "no short flag on full frames", shorts, 0);

        // R8: restart after 100 bits, then a full frame, then trailing bits
        send_frame(2, 100, 1'b0);
        send_frame(3, 256, 1'b0);
        settle();
        chk(shorts == 1, "R8", "short frame flag count", shorts, 1);
        chk(expq.size() == 0, "R8", "kept slots of short frame and next frame", expq.size(), 0);
        chk(strobes == 52 + 10 + 26, "R8", "strobe total after short frame", strobes, 88);

        // R7: bits past bit 255 without new start are dropped
        idle_bits(60);
        settle();
        chk(strobes == 88, "R7", "no strobes from trailing bits", strobes, 88);

        drive_bit(1'b1, 1'b0, 1'b0);
        send_frame(4, 256, 1'b0);
        idle_bits(5);
        settle();
        chk(expq.size() == 0, "R4", "patterned frame delivered", expq.size(), 0);
        chk(starts == exp_starts, "R2", "total frame starts", starts, exp_starts);
        chk(o2_dir1 == 0, "R9", "disabled in-line strobes", o2_dir1, 0);
        chk(o2_dir0 == exp_dir0, "R9", "out-line strobes with in-line disabled", o2_dir0, exp_dir0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule